// File: doc/BRIEF.md
# PCI Configuration Header Register File

This block holds the identification and base-address part of a PCI type-0 configuration header for a network function. An upstream bus-cycle decoder hands it a dword register index together with a read strobe, a write strobe, four byte enables and 32-bit write data. The block returns 32-bit read data on the cycle after a read strobe. Each field follows its own rule. Some are fixed constants. Some are hard-wired to zero and drop writes. Some are writable byte by byte.

The block decodes two base address registers, one for I/O space and one for memory space. Each claims a 256-byte window, so only bits 31:8 of each can be written. The current base addresses and the latency timer value leave the block as plain outputs, so the address-match and bus-master logic can use them directly.

Top module: `pci_cfg_hdr`

## Requirements
- R1: A read of dword index 2 returns the revision constant in bits 7:0, programming interface 00h in bits 15:8, sub-class 00h in bits 23:16 and base-class 02h (network controller) in bits 31:24. Writes to index 2 change nothing.
- R2: A read of dword index 3 returns 00h in bits 7:0 (cache line size), 23:16 (header type) and 31:24 (BIST), whatever was written to those bytes.
- R3: The latency timer sits in bits 15:8 of index 3. A write with byte enable 1 set stores it, and it appears on `lat_timer` and in read data.
- R4: A read of index 4 (I/O base register) returns the stored base in bits 31:8 and 01h in bits 7:0. Writes to bits 7:0 are ignored.
- R5: A read of index 5 (memory base register) returns the stored base in bits 31:8 and 00h in bits 7:0. Writes to bits 7:0 are ignored.
- R6: After FFFFFFFFh is written to index 4, a read returns FFFFFF01h. After the same write to index 5, a read returns FFFFFF00h.
- R7: A write updates only the bytes whose byte enable bit (bit n for bits 8n+7:8n) is set. All other bytes keep their value.
- R8: A read of any index other than 2 to 5 returns 0. A write to such an index changes no stored field.
- R9: A synchronous active-low reset clears both base fields, the latency timer and the read data to 0.
- R10: Read data is registered. It shows the value from before any write in the same cycle as the read strobe, and it holds while no read strobe is given.
- R11: `io_base` and `mem_base` carry the stored base addresses in bits 31:8, with bits 7:0 at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_idx | input | 6 | Dword register index |
| cfg_rd | input | 1 | Read strobe |
| cfg_wr | input | 1 | Write strobe |
| cfg_be | input | 4 | Byte enables for the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| io_base | output | 32 | Decoded I/O window base |
| mem_base | output | 32 | Decoded memory window base |
| lat_timer | output | 8 | Latency timer value |

## Verification
The hardest case to reach is a read and a write to the same base register in the same cycle under a partial byte-enable mask. The read must return the old word, and the next read must show only the enabled bytes changed. The bench forces this case by design: directed steps issue both strobes at once, and a long random phase draws indices, strobes and masks at random. A behavioural model applies every write only after it has taken that cycle's read.

// File: rtl/pci_cfg_pkg.sv
// Package: shared constants and types of the configuration header.
// Assumes a dword-indexed header in which the identification, misc and
// base-register dwords sit at the standard type-0 positions.
package pci_cfg_pkg;
    localparam int unsigned DW_CLASS  = 2;
    localparam int unsigned DW_MISC   = 3;
    localparam int unsigned DW_IOBAR  = 4;
    localparam int unsigned DW_MEMBAR = 5;

    localparam logic [7:0] CLASS_NETWORK = 8'h02;
    localparam logic [7:0] SUBCLASS_ETH  = 8'h00;
    localparam logic [7:0] PROG_IF_NONE  = 8'h00;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CLASS,
        SEL_MISC,
        SEL_IOBAR,
        SEL_MEMBAR
    } rd_sel_e;
endpackage

// File: rtl/pci_cfg_byte_reg.sv
// Module: one writable byte with a reset value.
// Assumes the caller has already qualified the write strobe with the
// register hit and the matching byte enable.
module pci_cfg_byte_reg #(
    parameter int unsigned W         = 8,
    parameter logic [W-1:0] RST_VAL  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    // Store the byte on a qualified write, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    q_o <= RST_VAL;
        else if (wr_i) q_o <= d_i;
    end
endmodule

// File: rtl/pci_cfg_bar.sv
// Module: base address register that claims a 2**WIN_BITS byte window.
// Lanes below the window size are hard-wired to zero. Lanes above it are
// writable under their byte enable. LOW_CONST supplies the read-only
// type bits. Assumes WIN_BITS is a non-zero multiple of 8.
module pci_cfg_bar #(
    parameter int unsigned  DW        = 32,
    parameter int unsigned  WIN_BITS  = 8,
    parameter logic [DW-1:0] LOW_CONST = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_i,
    input  logic [DW/8-1:0] be_i,
    input  logic [DW-1:0]   wdata_i,
    output logic [DW-1:0]   base_o,
    output logic [DW-1:0]   rdata_o
);
    localparam int unsigned LANES       = DW / 8;
    localparam int unsigned FIXED_LANES = WIN_BITS / 8;

    logic unused_lo;
    assign unused_lo = ^{be_i[FIXED_LANES-1:0], wdata_i[WIN_BITS-1:0]};

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        if (l < FIXED_LANES) begin : g_fixed
            assign base_o[l*8 +: 8] = 8'h00;
        end else begin : g_wr
            logic [7:0] q;
            // Update this lane only when its byte enable is set.
            always_ff @(posedge clk) begin
                if (!rst_n)                q <= 8'h00;
                else if (wr_i && be_i[l])  q <= wdata_i[l*8 +: 8];
            end
            assign base_o[l*8 +: 8] = q;
        end
    end

    // Combine the writable base with the read-only type bits.
    assign rdata_o = base_o | LOW_CONST;
endmodule

// File: rtl/pci_cfg_rd_mux.sv
// Module: builds the read word for the selected header dword.
// Assumes the select is already decoded. Unknown selects read as zero.
module pci_cfg_rd_mux #(
    parameter int unsigned DW = 32
) (
    input  pci_cfg_pkg::rd_sel_e sel_i,
    input  logic [7:0]           rev_i,
    input  logic [7:0]           lat_i,
    input  logic [DW-1:0]        iobar_i,
    input  logic [DW-1:0]        membar_i,
    output logic [DW-1:0]        word_o
);
    import pci_cfg_pkg::*;

    // Pick the word for the selected dword.
    always_comb begin
        word_o = '0;
        unique case (sel_i)
            SEL_CLASS:  word_o = DW'({CLASS_NETWORK, SUBCLASS_ETH, PROG_IF_NONE, rev_i});
            SEL_MISC:   word_o = DW'({8'h00, 8'h00, lat_i, 8'h00});
            SEL_IOBAR:  word_o = iobar_i;
            SEL_MEMBAR: word_o = membar_i;
            default:    word_o = '0;
        endcase
    end
endmodule

// File: rtl/pci_cfg_hdr.sv
// Module: configuration header register file, top level.
// Decodes the dword index, routes writes to the latency byte and the two
// base registers, and registers the read word. Assumes strobes last one
// cycle per access and that reads and writes may coincide.
module pci_cfg_hdr #(
    parameter int unsigned IDX_W    = 6,
    parameter int unsigned DW       = 32,
    parameter int unsigned WIN_BITS = 8,
    parameter logic [7:0]  REV_ID   = 8'h10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic            cfg_rd,
    input  logic            cfg_wr,
    input  logic [DW/8-1:0] cfg_be,
    input  logic [DW-1:0]   cfg_wdata,
    output logic [DW-1:0]   cfg_rdata,
    output logic [DW-1:0]   io_base,
    output logic [DW-1:0]   mem_base,
    output logic [7:0]      lat_timer
);
    import pci_cfg_pkg::*;

    localparam logic [DW-1:0] IO_FLAG  = DW'(1);
    localparam logic [DW-1:0] MEM_FLAG = '0;
    localparam int unsigned   LAT_LANE = 1;

    rd_sel_e       sel;
    logic          hit_misc, hit_io, hit_mem;
    logic [DW-1:0] iobar_word, membar_word, rd_word;

    // Decode the dword index into a register select.
    always_comb begin
        sel = SEL_NONE;
        if      (cfg_idx == IDX_W'(DW_CLASS))  sel = SEL_CLASS;
        else if (cfg_idx == IDX_W'(DW_MISC))   sel = SEL_MISC;
        else if (cfg_idx == IDX_W'(DW_IOBAR))  sel = SEL_IOBAR;
        else if (cfg_idx == IDX_W'(DW_MEMBAR)) sel = SEL_MEMBAR;
    end

    assign hit_misc = cfg_wr && (sel == SEL_MISC);
    assign hit_io   = cfg_wr && (sel == SEL_IOBAR);
    assign hit_mem  = cfg_wr && (sel == SEL_MEMBAR);

    pci_cfg_byte_reg #(.W(8), .RST_VAL(8'h00)) u_lat (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_i  (hit_misc && cfg_be[LAT_LANE]),
        .d_i   (cfg_wdata[LAT_LANE*8 +: 8]),
        .q_o   (lat_timer)
    );

    pci_cfg_bar #(.DW(DW), .WIN_BITS(WIN_BITS), .LOW_CONST(IO_FLAG)) u_iobar (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (hit_io),
        .be_i    (cfg_be),
        .wdata_i (cfg_wdata),
        .base_o  (io_base),
        .rdata_o (iobar_word)
    );

    pci_cfg_bar #(.DW(DW), .WIN_BITS(WIN_BITS), .LOW_CONST(MEM_FLAG)) u_membar (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (hit_mem),
        .be_i    (cfg_be),
        .wdata_i (cfg_wdata),
        .base_o  (mem_base),
        .rdata_o (membar_word)
    );

    pci_cfg_rd_mux #(.DW(DW)) u_mux (
        .sel_i    (sel),
        .rev_i    (REV_ID),
        .lat_i    (lat_timer),
        .iobar_i  (iobar_word),
        .membar_i (membar_word),
        .word_o   (rd_word)
    );

    // Capture the read word on a read strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_rdata <= '0;
        else if (cfg_rd) cfg_rdata <= rd_word;
    end
endmodule

// File: rtl/pci_cfg_hdr_chk.sv
// Module: property checker for pci_cfg_hdr, attached by bind.
// Assumes the default index width and the standard dword positions.
module pci_cfg_hdr_chk #(
    parameter int unsigned IDX_W  = 6,
    parameter int unsigned DW     = 32,
    parameter logic [7:0]  REV_ID = 8'h10
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IDX_W-1:0] cfg_idx,
    input logic             cfg_rd,
    input logic             cfg_wr,
    input logic [DW/8-1:0]  cfg_be,
    input logic [DW-1:0]    cfg_wdata,
    input logic [DW-1:0]    cfg_rdata,
    input logic [DW-1:0]    io_base,
    input logic [DW-1:0]    mem_base,
    input logic [7:0]       lat_timer
);
    logic unused_chk;
    assign unused_chk = ^{cfg_wdata[DW-1:16], cfg_wdata[7:0], cfg_be[DW/8-1:2], cfg_be[0]};

    a_r1_id_word: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd && cfg_idx == IDX_W'(2) |=> cfg_rdata == DW'({8'h02, 8'h00, 8'h00, REV_ID}));

    a_r2_misc_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd && cfg_idx == IDX_W'(3) |=> cfg_rdata[7:0] == 8'h00 && cfg_rdata[31:16] == 16'h0);

    a_r3_lat_write: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && cfg_idx == IDX_W'(3) && cfg_be[1] |=> lat_timer == $past(cfg_wdata[15:8]));

    a_r3_lat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr && cfg_idx == IDX_W'(3) && cfg_be[1]) |=> $stable(lat_timer));

    a_r4_io_flag: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd && cfg_idx == IDX_W'(4) |=> cfg_rdata[7:0] == 8'h01);

    a_r5_mem_flag: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd && cfg_idx == IDX_W'(5) |=> cfg_rdata[7:0] == 8'h00);

    a_r8_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd && (cfg_idx < IDX_W'(2) || cfg_idx > IDX_W'(5)) |=> cfg_rdata == '0);

    a_r8_io_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr && cfg_idx == IDX_W'(4)) |=> $stable(io_base));

    a_r8_mem_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_wr && cfg_idx == IDX_W'(5)) |=> $stable(mem_base));

    a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rd |=> $stable(cfg_rdata));

    a_r11_io_match: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd && cfg_idx == IDX_W'(4) |=> cfg_rdata[31:8] == $past(io_base[31:8]));

    a_r11_mem_match: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd && cfg_idx == IDX_W'(5) |=> cfg_rdata[31:8] == $past(mem_base[31:8]));
endmodule

bind pci_cfg_hdr pci_cfg_hdr_chk #(.IDX_W(IDX_W), .DW(DW), .REV_ID(REV_ID)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_idx   (cfg_idx),
    .cfg_rd    (cfg_rd),
    .cfg_wr    (cfg_wr),
    .cfg_be    (cfg_be),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .io_base   (io_base),
    .mem_base  (mem_base),
    .lat_timer (lat_timer)
);

// File: tb/pci_cfg_hdr_tb.sv
`timescale 1ns/1ps
module pci_cfg_hdr_tb;
    localparam logic [7:0] REV = 8'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  cfg_idx = '0;
    logic        cfg_rd = 1'b0, cfg_wr = 1'b0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata, io_base, mem_base;
    logic [7:0]  lat_timer;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // behavioural model state
    logic [23:0] m_io = '0, m_mem = '0;
    logic [7:0]  m_lat = '0;
    logic [31:0] m_rd = '0;
    string       m_tag = "R9";

    always #2 clk = ~clk;

    pci_cfg_hdr u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_idx(cfg_idx), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .io_base(io_base), .mem_base(mem_base), .lat_timer(lat_timer)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [5:0] idx);
        case (idx)
            6'd2:    return {8'h02, 8'h00, 8'h00, REV};
            6'd3:    return {16'h0000, m_lat, 8'h00};
            6'd4:    return {m_io, 8'h01};
            6'd5:    return {m_mem, 8'h00};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [5:0] idx);
        case (idx)
            6'd2: return "R1";
            6'd3: return "R2";
            6'd4: return "R4";
            6'd5: return "R5";
            default: return "R8";
        endcase
    endfunction

    // One clock of stimulus, model update and comparison of every output.
    task automatic step(input logic [5:0] idx, input bit rd, input bit wr,
                        input logic [3:0] be, input logic [31:0] wd);
        cfg_idx = idx; cfg_rd = rd; cfg_wr = wr; cfg_be = be; cfg_wdata = wd;
        @(posedge clk);
        if (!rst_n) begin
            m_io = '0; m_mem = '0; m_lat = '0; m_rd = '0; m_tag = "R9";
        end else begin
            if (rd) begin
                m_rd = model_read(idx);
                m_tag = tag_of(idx);
            end else begin
                m_tag = "R10";
            end
            if (wr) begin
                if (idx == 6'd3 && be[1]) m_lat = wd[15:8];
                for (int b = 1; b < 4; b++) begin
                    if (be[b] && idx == 6'd4) m_io[(b-1)*8 +: 8] = wd[b*8 +: 8];
                    if (be[b] && idx == 6'd5) m_mem[(b-1)*8 +: 8] = wd[b*8 +: 8];
                end
            end
        end
        #1;
        check(cfg_rdata === m_rd, m_tag, cfg_rdata, m_rd);
        check(lat_timer === m_lat, "R3", {24'h0, lat_timer}, {24'h0, m_lat});
        check(io_base === {m_io, 8'h00}, "R11", io_base, {m_io, 8'h00});
        check(mem_base === {m_mem, 8'h00}, "R11", mem_base, {m_mem, 8'h00});
    endtask

    task automatic idle();
        step(6'd0, 1'b0, 1'b0, 4'h0, 32'h0);
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %08h expected %08h", 32'h0, 32'h1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        rst_n = 1'b0;
        repeat (3) step(6'd4, 1'b1, 1'b1, 4'hF, 32'hFFFF_FFFF);
        rst_n = 1'b1;
        idle();
        check(cfg_rdata == 32'h0 && io_base == 32'h0 && mem_base == 32'h0 && lat_timer == 8'h0,
              "R9", cfg_rdata | io_base | mem_base, 32'h0);

        // R1: identification dword, write ignored
        step(6'd2, 1'b0, 1'b1, 4'hF, 32'hDEAD_BEEF);
        step(6'd2, 1'b1, 1'b0, 4'h0, 32'h0);
        check(cfg_rdata == 32'h0200_0010, "R1", cfg_rdata, 32'h0200_0010);

        // R2 / R3: misc dword, only the latency byte sticks
        step(6'd3, 1'b0, 1'b1, 4'hF, 32'hFFFF_FFFF);
        step(6'd3, 1'b1, 1'b0, 4'h0, 32'h0);
        check(cfg_rdata == 32'h0000_FF00, "R2", cfg_rdata, 32'h0000_FF00);
        check(lat_timer == 8'hFF, "R3", {24'h0, lat_timer}, 32'hFF);

        // R6: sizing probe on both base registers
        step(6'd4, 1'b0, 1'b1, 4'hF, 32'hFFFF_FFFF);
        step(6'd4, 1'b1, 1'b0, 4'h0, 32'h0);
        check(cfg_rdata == 32'hFFFF_FF01, "R6", cfg_rdata, 32'hFFFF_FF01);
        step(6'd5, 1'b0, 1'b1, 4'hF, 32'hFFFF_FFFF);
        step(6'd5, 1'b1, 1'b0, 4'h0, 32'h0);
        check(cfg_rdata == 32'hFFFF_FF00, "R6", cfg_rdata, 32'hFFFF_FF00);

        // R7: partial byte enables, R4 low byte ignored
        step(6'd4, 1'b0, 1'b1, 4'b0101, 32'h1234_5678);
        step(6'd4, 1'b1, 1'b0, 4'h0, 32'h0);
        check(cfg_rdata == 32'hFF34_FF01, "R7", cfg_rdata, 32'hFF34_FF01);
        step(6'd5, 1'b0, 1'b1, 4'b1001, 32'hAB00_00CD);
        step(6'd5, 1'b1, 1'b0, 4'h0, 32'h0);
        check(cfg_rdata == 32'hABFF_FF00, "R7", cfg_rdata, 32'hABFF_FF00);

        // R8: unimplemented offsets
        step(6'd7, 1'b0, 1'b1, 4'hF, 32'h0);
        step(6'h3F, 1'b0, 1'b1, 4'hF, 32'h0);
        step(6'd7, 1'b1, 1'b0, 4'h0, 32'h0);
        check(cfg_rdata == 32'h0, "R8", cfg_rdata, 32'h0);
        check(io_base == 32'hFF34_FF00, "R8", io_base, 32'hFF34_FF00);

        // R10: same-cycle read and write returns the old word, then holds
        step(6'd4, 1'b1, 1'b1, 4'b1110, 32'h00C0_FF00);
        check(cfg_rdata == 32'hFF34_FF01, "R10", cfg_rdata, 32'hFF34_FF01);
        idle(); idle();
        check(cfg_rdata == 32'hFF34_FF01, "R10", cfg_rdata, 32'hFF34_FF01);
        step(6'd4, 1'b1, 1'b0, 4'h0, 32'h0);
        check(cfg_rdata == 32'h00C0_FF01, "R10", cfg_rdata, 32'h00C0_FF01);

        // R9: reset mid-run
        rst_n = 1'b0;
        idle();
        rst_n = 1'b1;
        step(6'd5, 1'b1, 1'b0, 4'h0, 32'h0);
        check(cfg_rdata == 32'h0 && lat_timer == 8'h0, "R9", cfg_rdata, 32'h0);

        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            logic [5:0] ridx;
            ridx = ($urandom % 4 == 0) ? 6'($urandom) : 6'(2 + $urandom % 4);
            step(ridx, 1'($urandom), 1'($urandom), 4'($urandom), $urandom);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule